// File: doc/BRIEF.md
# I2C Bus Monitor

This block watches the clock and data lines of a two-wire I2C bus without ever
taking part in a transfer. It recognises Start, Repeated Start and Stop
conditions. It collects every byte that crosses the bus, whether address or
data, together with the acknowledge bit that follows the byte. Each completed
byte, and each Stop, becomes one item. The item is packed into a single
readable word and held there until software takes it with a read strobe.

Only one item is buffered. When clock stretching is off, the word stays valid
until the next item on the bus has fully completed. If an unread item is
replaced, a sticky overrun flag records the loss. When clock stretching is on,
the block requests that SCL be held low after the falling clock edge that ends
a byte. It keeps that request until the item is read, so the bus pauses instead
of losing data. The raw line levels pass through two-flop synchronisers, so
they may be asynchronous to the system clock.

Top module: `bus_watch_mon`

## Requirements
- R1: While `watch_en` is low, bus activity is ignored and `mon_valid`, `mon_overrun`, `scl_hold` and `mon_word` read 0. Dropping `watch_en` clears all of them. After reset all outputs are 0.
- R2: After a Start, SDA is sampled on each rising SCL edge. The first 8 samples form the byte, MSB first, in `mon_word[7:0]`. The item completes on the falling SCL edge that follows the 9th rising edge.
- R3: `mon_word[10]` is 1 when SDA was high at the 9th rising SCL edge (not acknowledged) and 0 when it was low.
- R4: `mon_word[8]` is 1 only for the first byte after a Start or Repeated Start. Later bytes in the same transfer carry 0.
- R5: `mon_word[9]` is 1 for the first byte after a Start that occurred with no Stop since the previous Start (a Repeated Start). Such a byte also has bit 8 set.
- R6: A Stop (SDA rising while SCL is high) completes an item whose word is 0x800: bit 11 set and every other bit 0. A Start is SDA falling while SCL is high.
- R7: `mon_valid` rises when an item completes and falls after a `rd_strobe` cycle in which no new item completes. If an item completes in the same cycle as the read, `mon_valid` stays 1.
- R8: `mon_overrun` is set when an item completes while `mon_valid` is 1 and no read occurs in that cycle. It stays set until `watch_en` goes low.
- R9: With `stretch_en` high, `scl_hold` rises one cycle after a byte item completes and stays high until the cycle after a `rd_strobe`. A Stop item never raises it, and `scl_hold` is 0 whenever `stretch_en` is low.
- R10: A change on `scl_in` or `sda_in` that completes an item shows on the outputs after the third rising clock edge that samples the new level, and not before.
- R11: A completed word remains unchanged on `mon_word` until the next item completes, whether or not it has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| watch_en | input | 1 | Monitor enable; low clears and idles the block |
| stretch_en | input | 1 | Allows SCL hold requests while an item is unread |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| rd_strobe | input | 1 | One-cycle read of the monitor word |
| mon_word | output | 12 | {stop, nack, repeated start, start, byte[7:0]} |
| mon_valid | output | 1 | An unread item is present |
| mon_overrun | output | 1 | Sticky flag: an unread item was overwritten |
| scl_hold | output | 1 | Request to pull SCL low |

## Verification
A bus-line change that finishes an item reaches the outputs three clock edges after it is first sampled: two synchroniser stages, then the report register. A read strobe acts on the very next edge, and `scl_hold` follows the hold register combinationally. The reference model in the bench therefore uses the line levels sampled two edges earlier, together with the current strobe and configuration values. It is compared on every falling clock edge. The directed latency check counts edges after the final Stop edge, expecting the old word after the second edge and the Stop word after the third. All stimulus changes 1 ns after a rising edge, so no check sits on an edge.

// File: rtl/bus_watch_pkg.sv
package bus_watch_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BYTE_W + 4;

  typedef struct packed {
    logic              stop;
    logic              nack;
    logic              rstart;
    logic              start;
    logic [BYTE_W-1:0] data;
  } watch_word_t;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int               WIDTH   = 2,
  parameter int               STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/bus_cond_det.sv
module bus_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise = scl & ~scl_q;
  assign scl_fall = ~scl & scl_q;
  assign start_ev = scl & scl_q & sda_q & ~sda;
  assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              sda,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  output logic              byte_done,
  output logic              stop_done,
  output logic [BYTE_W-1:0] byte_val,
  output logic              nack_val,
  output logic              start_val,
  output logic              rstart_val
);
  localparam int              CNT_W   = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] ACK_POS = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_C  = CNT_W'(BYTE_W + 1);

  logic              in_frame_q, in_frame_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              ack_q, ack_d;
  logic              pst_q, pst_d;
  logic              prs_q, prs_d;
  logic              done_c, stopd_c;

  always_comb begin
    in_frame_d = in_frame_q;
    cnt_d      = cnt_q;
    sh_d       = sh_q;
    ack_d      = ack_q;
    pst_d      = pst_q;
    prs_d      = prs_q;
    done_c     = 1'b0;
    stopd_c    = 1'b0;
    if (!en) begin
      in_frame_d = 1'b0;
      cnt_d      = '0;
      sh_d       = '0;
      ack_d      = 1'b0;
      pst_d      = 1'b0;
      prs_d      = 1'b0;
    end else if (start_ev) begin
      in_frame_d = 1'b1;
      cnt_d      = '0;
      pst_d      = 1'b1;
      prs_d      = in_frame_q;
    end else if (stop_ev) begin
      in_frame_d = 1'b0;
      cnt_d      = '0;
      pst_d      = 1'b0;
      prs_d      = 1'b0;
      stopd_c    = 1'b1;
    end else if (scl_rise && in_frame_q && (cnt_q < LAST_C)) begin
      if (cnt_q < ACK_POS) sh_d = {sh_q[BYTE_W-2:0], sda};
      else                 ack_d = sda;
      cnt_d = cnt_q + 1'b1;
    end else if (scl_fall && in_frame_q && (cnt_q == LAST_C)) begin
      done_c = 1'b1;
      cnt_d  = '0;
      pst_d  = 1'b0;
      prs_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame_q <= 1'b0;
      cnt_q      <= '0;
      sh_q       <= '0;
      ack_q      <= 1'b0;
      pst_q      <= 1'b0;
      prs_q      <= 1'b0;
    end else begin
      in_frame_q <= in_frame_d;
      cnt_q      <= cnt_d;
      sh_q       <= sh_d;
      ack_q      <= ack_d;
      pst_q      <= pst_d;
      prs_q      <= prs_d;
    end
  end

  assign byte_done  = done_c;
  assign stop_done  = stopd_c;
  assign byte_val   = sh_q;
  assign nack_val   = ack_q;
  assign start_val  = pst_q;
  assign rstart_val = prs_q;

  // R2
  bit_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST_C);

  // R2
  done_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |=> (cnt_q == '0) && !start_val);

  // R5
  rstart_has_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rstart_val |-> start_val);
endmodule

// File: rtl/bus_watch_mon.sv
module bus_watch_mon
  import bus_watch_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              watch_en,
  input  logic              stretch_en,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] mon_word,
  output logic              mon_valid,
  output logic              mon_overrun,
  output logic              scl_hold
);
  logic              rst_sync_n;
  logic [1:0]        lines_s;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic              byte_done, stop_done, item_done;
  logic [BYTE_W-1:0] byte_val;
  logic              nack_val, start_val, rstart_val;
  watch_word_t       new_word, word_q, word_d;
  logic              word_we;
  logic              valid_q, valid_d;
  logic              ovr_q, ovr_d;
  logic              req_q, req_d;

  line_sync #(.WIDTH(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_sync_n)
  );

  line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_line_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_in, sda_in}), .dout(lines_s)
  );

  bus_cond_det u_det (
    .clk(clk), .rst_n(rst_sync_n), .scl(lines_s[1]), .sda(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  frame_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_sync_n), .en(watch_en), .sda(lines_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .byte_done(byte_done), .stop_done(stop_done),
    .byte_val(byte_val), .nack_val(nack_val),
    .start_val(start_val), .rstart_val(rstart_val)
  );

  assign item_done = byte_done | stop_done;

  always_comb begin
    new_word = '0;
    if (stop_done) begin
      new_word.stop = 1'b1;
    end else begin
      new_word.nack   = nack_val;
      new_word.rstart = rstart_val;
      new_word.start  = start_val;
      new_word.data   = byte_val;
    end
  end

  always_comb begin
    word_d  = word_q;
    valid_d = valid_q;
    ovr_d   = ovr_q;
    req_d   = req_q;
    word_we = 1'b0;
    if (!watch_en) begin
      word_d  = '0;
      word_we = 1'b1;
      valid_d = 1'b0;
      ovr_d   = 1'b0;
      req_d   = 1'b0;
    end else begin
      word_we = item_done;
      if (item_done) word_d = new_word;
      valid_d = item_done | (valid_q & ~rd_strobe);
      ovr_d   = ovr_q | (item_done & valid_q & ~rd_strobe);
      req_d   = stretch_en & (byte_done | (req_q & ~rd_strobe));
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
      req_q   <= 1'b0;
    end else begin
      if (word_we) word_q <= word_d;
      valid_q <= valid_d;
      ovr_q   <= ovr_d;
      req_q   <= req_d;
    end
  end

  assign mon_word    = word_q;
  assign mon_valid   = valid_q;
  assign mon_overrun = ovr_q;
  assign scl_hold    = req_q & stretch_en & watch_en;

  // R7
  valid_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    item_done && watch_en |=> mon_valid);

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_strobe && !item_done |=> !mon_valid);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mon_overrun && watch_en |=> mon_overrun);

  // R1
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !watch_en |=> !mon_valid && !mon_overrun && (mon_word == '0));

  // R9
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_strobe && !byte_done |=> !scl_hold);

  // R6
  stop_word_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stop_done && watch_en |=> mon_word == WORD_W'(1 << (WORD_W - 1)));
endmodule

// File: tb/bus_watch_mon_tb_top.sv
module bus_watch_mon_tb_top;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_drv, st_drv, scl_drv, sda_drv, rd_drv;
  logic [11:0] mon_word;
  logic        mon_valid, mon_overrun, scl_hold;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  bit ended  = 0;

  // reference model state
  int m_in, m_cnt, m_sh, m_ack, m_pst, m_prs;
  int m_word, m_valid, m_ovr, m_req;
  int h1s, h2s, h3s, h1d, h2d, h3d;

  always #2 clk = ~clk;

  bus_watch_mon dut_i (
    .clk(clk), .rst_n(rst_n), .watch_en(en_drv), .stretch_en(st_drv),
    .scl_in(scl_drv), .sda_in(sda_drv), .rd_strobe(rd_drv),
    .mon_word(mon_word), .mon_valid(mon_valid),
    .mon_overrun(mon_overrun), .scl_hold(scl_hold)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    ended = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // behavioural reference, fed by line levels sampled two edges earlier
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in = 0; m_cnt = 0; m_sh = 0; m_ack = 0; m_pst = 0; m_prs = 0;
      m_word = 0; m_valid = 0; m_ovr = 0; m_req = 0;
      h1s = 1; h2s = 1; h3s = 1; h1d = 1; h2d = 1; h3d = 1;
    end else begin
      int cs, ps, cd, pd, byte_fin, stop_fin, item, nw;
      cs = h2s; ps = h3s; cd = h2d; pd = h3d;
      byte_fin = 0; stop_fin = 0; nw = 0;
      if (!en_drv) begin
        m_in = 0; m_cnt = 0; m_sh = 0; m_ack = 0; m_pst = 0; m_prs = 0;
      end else if (cs == 1 && ps == 1 && pd == 1 && cd == 0) begin
        m_prs = m_in; m_pst = 1; m_in = 1; m_cnt = 0;
      end else if (cs == 1 && ps == 1 && pd == 0 && cd == 1) begin
        m_in = 0; m_cnt = 0; m_pst = 0; m_prs = 0; stop_fin = 1; nw = 'h800;
      end else if (cs == 1 && ps == 0 && m_in == 1 && m_cnt < 9) begin
        if (m_cnt < 8) m_sh = ((m_sh << 1) | cd) & 255;
        else m_ack = cd;
        m_cnt++;
      end else if (cs == 0 && ps == 1 && m_in == 1 && m_cnt == 9) begin
        byte_fin = 1;
        nw = (m_ack << 10) | (m_prs << 9) | (m_pst << 8) | m_sh;
        m_cnt = 0; m_pst = 0; m_prs = 0;
      end
      item = byte_fin | stop_fin;
      if (!en_drv) begin
        m_word = 0; m_valid = 0; m_ovr = 0; m_req = 0;
      end else begin
        if (item && m_valid && !rd_drv) m_ovr = 1;
        if (item) m_word = nw;
        m_valid = (item || (m_valid && !rd_drv)) ? 1 : 0;
        m_req = (st_drv && (byte_fin || (m_req && !rd_drv))) ? 1 : 0;
      end
      h3s = h2s; h2s = h1s; h1s = scl_drv;
      h3d = h2d; h2d = h1d; h1d = sda_drv;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      chk("R2 word", {20'd0, mon_word}, m_word);
      chk("R7 valid", {31'd0, mon_valid}, m_valid);
      chk("R8 overrun", {31'd0, mon_overrun}, m_ovr);
      chk("R9 hold", {31'd0, scl_hold}, (m_req != 0 && st_drv && en_drv) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000 && !ended) begin
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_bit(input logic v);
    sda_drv = v;    tick(H);
    scl_drv = 1'b1; tick(H);
    scl_drv = 1'b0; tick(H);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(H);
    scl_drv = 1'b1; tick(H);
    sda_drv = 1'b0; tick(H);
    scl_drv = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(H);
    scl_drv = 1'b1; tick(H);
    sda_drv = 1'b1;
  endtask

  task automatic bus_byte(input logic [7:0] b, input logic nak);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    bus_bit(nak);
  endtask

  task automatic do_read();
    rd_drv = 1'b1; tick(1);
    rd_drv = 1'b0; tick(1);
  endtask

  initial begin
    rst_n = 1'b0; en_drv = 1'b0; st_drv = 1'b0;
    scl_drv = 1'b1; sda_drv = 1'b1; rd_drv = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick(4);
    // R1 reset state
    chk("R1 reset word", {20'd0, mon_word}, 0);
    chk("R1 reset valid", {31'd0, mon_valid}, 0);
    chk("R1 reset hold", {31'd0, scl_hold}, 0);

    // R1 traffic ignored while disabled
    bus_start(); bus_byte(8'hC3, 1'b0); bus_stop(); tick(H);
    chk("R1 off valid", {31'd0, mon_valid}, 0);
    chk("R1 off word", {20'd0, mon_word}, 0);

    en_drv = 1'b1; tick(2);
    bus_start(); bus_byte(8'hA5, 1'b0);
    chk("R2 byte", {24'd0, mon_word[7:0]}, 8'hA5);
    chk("R4 start flag", {31'd0, mon_word[8]}, 1);
    chk("R5 no restart", {31'd0, mon_word[9]}, 0);
    chk("R3 ack", {31'd0, mon_word[10]}, 0);
    chk("R7 valid set", {31'd0, mon_valid}, 1);
    do_read();
    chk("R7 read clears", {31'd0, mon_valid}, 0);

    bus_byte(8'h3C, 1'b1);
    chk("R3 nack", {31'd0, mon_word[10]}, 1);
    chk("R4 second byte", {31'd0, mon_word[8]}, 0);
    tick(20);
    chk("R11 word held", {20'd0, mon_word}, 32'h43C);

    bus_start(); bus_byte(8'h81, 1'b0);
    chk("R5 restart word", {20'd0, mon_word}, 32'h381);
    chk("R8 overrun", {31'd0, mon_overrun}, 1);

    // R10: Stop edge driven now; word changes after third edge
    bus_stop();
    tick(2);
    chk("R10 not yet", {20'd0, mon_word}, 32'h381);
    tick(1);
    chk("R10 R6 stop word", {20'd0, mon_word}, 32'h800);
    chk("R8 still set", {31'd0, mon_overrun}, 1);

    en_drv = 1'b0; tick(2);
    chk("R1 disable clears overrun", {31'd0, mon_overrun}, 0);
    chk("R1 disable clears valid", {31'd0, mon_valid}, 0);
    en_drv = 1'b1; st_drv = 1'b1; tick(2);

    bus_start(); bus_byte(8'h5A, 1'b0);
    chk("R9 hold raised", {31'd0, scl_hold}, 1);
    tick(10);
    chk("R9 hold kept", {31'd0, scl_hold}, 1);
    chk("R11 stretched word", {20'd0, mon_word}, 32'h15A);
    do_read();
    chk("R9 hold released", {31'd0, scl_hold}, 0);
    bus_stop(); tick(H);
    chk("R9 no hold on stop", {31'd0, scl_hold}, 0);
    chk("R6 stop item", {20'd0, mon_word}, 32'h800);
    tick(10);
    finish_run();
  end
endmodule